// File: doc/BRIEF.md
# Halting Serial Pattern Detector

This block watches a one-bit serial stream and raises a flag when the four most recent accepted bits, taken oldest first, spell 0110. It keeps three earlier bits in a history register. It compares each incoming bit with that history in the same cycle, so a match is recognised on the clock edge that accepts the fourth bit.

Detection is terminal. After the first match the flag latches high, the history freezes and the block refuses all further data. Only a synchronous reset brings it back to scanning. Bits arrive over a valid/ready handshake. A bit is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high on every cycle except when the block has halted. Back-pressure therefore appears only once, as the permanent stall that follows detection, and the sender must hold or drop its data from then until reset.

The history starts at 000. A stream that begins right after reset with 1,1,0 therefore completes the pattern through the implicit leading zero.

Top module: `seq_halt_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `flag`=0 and `in_ready`=1, and the history is cleared to 000. Because of this, the accepted bits 1,1,0 right after reset produce a match.
- R2: When a bit of 0 is accepted while the history holds 011 (oldest bit in the most significant position), `flag` is 1 from the cycle after that edge.
- R3: `flag` stays 0 on every cycle that follows no such match, including streams that hold 1001, 0111 or 1110 as their last four bits.
- R4: When an accepted bit does not complete a match, the history becomes its old low two bits followed by the new bit, a left shift.
- R5: On a cycle with `in_valid` low, no bit is taken, the history is unchanged and the flag is unchanged.
- R6: Once `flag` is 1, it stays 1 and `in_ready` stays 0 until reset, whatever arrives on `in_valid` and `in_bit`. A tail such as 110 after the match never re-arms detection.
- R7: A synchronous reset is the only way out of the halted state. A reset in the middle of a partial pattern discards the bits seen so far.
- R8: `in_ready` equals the inverse of `flag` on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sender offers a bit this cycle |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block will accept a bit this cycle (low only when halted) |
| flag | output | 1 | Pattern found; holds high until reset |

## Verification
The main stream has five non-matching bits followed by a matching sixth. It shows that detection waits for exactly the right four bits and is not fooled by partial prefixes. A 1,1,0 stream straight after reset confirms the history is seeded with zeros. A stream broken by idle cycles shows that only accepted beats shift the history. Pseudo-random streams, a reset inside a partial match, and a 1,1,0 tail sent after the halt separate the sticky halt from a continuously scanning detector. They also show that reset, and nothing else, discards state.

// File: rtl/seq_halt_pkg.sv
package seq_halt_pkg;
  localparam int HIST_W = 3;
  localparam int PAT_W = HIST_W + 1;
  localparam logic [PAT_W-1:0] TARGET = 4'b0110;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_HALT = 1'b1
  } det_state_t;
endpackage

// File: rtl/seq_halt_history.sv
module seq_halt_history #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] hist
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[W-2:0], din};
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/seq_halt_match.sv
module seq_halt_match #(
  parameter int W = 3,
  parameter logic [W:0] PAT = 4'b0110
) (
  input  logic [W-1:0] hist,
  input  logic         din,
  output logic         hit
);
  logic [W:0] window;

  always_comb begin
    window = {hist, din};
    hit = (window == PAT);
  end
endmodule

// File: rtl/seq_halt_ctl.sv
module seq_halt_ctl
  import seq_halt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic hit,
  output logic halted
);
  det_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SCAN;
    end else if (state_q == ST_SCAN && take && hit) begin
      state_q <= ST_HALT;
    end
  end

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/seq_halt_detect.sv
module seq_halt_detect
  import seq_halt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic flag
);
  logic [HIST_W-1:0] hist_q;
  logic              hit;
  logic              halted;
  logic              take;
  logic              shift_en;

  assign in_ready = !halted;
  assign take     = in_valid && in_ready;
  assign shift_en = take && !hit;
  assign flag     = halted;

  seq_halt_history #(.W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (in_bit),
    .hist     (hist_q)
  );

  seq_halt_match #(.W(HIST_W), .PAT(TARGET)) u_match (
    .hist (hist_q),
    .din  (in_bit),
    .hit  (hit)
  );

  seq_halt_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .hit    (hit),
    .halted (halted)
  );
endmodule

// File: rtl/seq_halt_detect_chk.sv
module seq_halt_detect_chk
  import seq_halt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_bit,
  input logic              in_ready,
  input logic              flag,
  input logic [HIST_W-1:0] hist
);
  logic accepted;
  logic completes;
  assign accepted  = in_valid && in_ready;
  assign completes = accepted && !in_bit && (hist == 3'b011);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!flag && in_ready && hist == '0));
  p_match_raise_r2: assert property (@(posedge clk) disable iff (rst) completes |=> flag);
  p_no_false_r3:    assert property (@(posedge clk) disable iff (rst) (in_ready && !completes) |=> !flag);
  p_shift_left_r4:  assert property (@(posedge clk) disable iff (rst)
                      (accepted && !completes) |=> hist == {$past(hist[HIST_W-2:0]), $past(in_bit)});
  p_idle_hold_r5:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(hist) && $stable(flag)));
  p_sticky_r6:      assert property (@(posedge clk) disable iff (rst) flag |=> (flag && !in_ready && $stable(hist)));
  p_exit_only_r7:   assert property (@(posedge clk) disable iff (rst) $fell(flag) |-> $past(rst));
  p_ready_inv_r8:   assert property (@(posedge clk) disable iff (rst) in_ready == !flag);
endmodule

bind seq_halt_detect seq_halt_detect_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_bit   (in_bit),
  .in_ready (in_ready),
  .flag     (flag),
  .hist     (hist_q)
);

// File: tb/seq_halt_detect_test.sv
module seq_halt_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic flag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model: integers only
  int  m_hist = 0;
  bit  m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_halt_detect uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .flag     (flag)
  );

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      m_hist = 0;
      m_flag = 1'b0;
    end else if (in_valid && !m_flag) begin
      if (!in_bit && m_hist == 3) m_flag = 1'b1;
      else m_hist = ((m_hist << 1) | int'(in_bit)) & 7;
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic compare();
    checks = checks + 1;
    if (flag !== m_flag || in_ready !== !m_flag) begin
      errors = errors + 1;
      $display("FAIL %s: actual flag=%b in_ready=%b expected flag=%b in_ready=%b",
               cur_req, flag, in_ready, m_flag, !m_flag);
    end
  endtask

  // drive one cycle at the falling edge, compare at the next falling edge
  task automatic step(input bit v, input bit b);
    in_valid = v;
    in_bit   = b;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare();
  endtask

  task automatic expect_flag(input string req, input bit exp);
    checks = checks + 1;
    if (flag !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual flag=%b expected flag=%b", req, flag, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    do_reset();
    expect_flag("R1 reset state", 1'b0);

    // five non-matching bits then a match on the sixth: R2, R3, R4
    cur_req = "R3";
    step(1, 0); step(1, 1); step(1, 0); step(1, 1); step(1, 1);
    expect_flag("R3 no match after five", 1'b0);
    cur_req = "R2";
    step(1, 0);
    expect_flag("R2 sixth bit match", 1'b1);

    // halted: inputs ignored, tail 110 does not re-arm (R6, R8)
    cur_req = "R6";
    step(1, 1); step(1, 1); step(1, 0); step(0, 0); step(1, 0); step(1, 1);
    expect_flag("R6 sticky after tail", 1'b1);

    // reset leaves halt; implicit zero history gives match on 110 (R7, R1)
    cur_req = "R7";
    do_reset();
    expect_flag("R7 reset exits halt", 1'b0);
    cur_req = "R1";
    step(1, 1); step(1, 1); step(1, 0);
    expect_flag("R1 seeded zeros match", 1'b1);

    // idle cycles take no bit (R5)
    do_reset();
    cur_req = "R5";
    step(1, 0); step(0, 0); step(1, 1); step(0, 0); step(0, 1);
    step(1, 1); step(0, 0); step(0, 0);
    expect_flag("R5 gaps no early match", 1'b0);
    step(1, 0);
    expect_flag("R5 match across gaps", 1'b1);

    // near-miss patterns (R3, R4)
    do_reset();
    cur_req = "R3";
    step(1, 1); step(1, 1); step(1, 1); step(1, 1);
    step(1, 1); step(1, 0); step(1, 0); step(1, 1);
    step(1, 0); step(1, 1); step(1, 1); step(1, 1);
    step(1, 1); step(1, 1); step(1, 1); step(1, 0);
    expect_flag("R3 near misses", 1'b0);

    // reset inside a partial pattern (R7)
    do_reset();
    cur_req = "R7";
    step(1, 0); step(1, 1); step(1, 1);
    do_reset();
    step(1, 0);
    expect_flag("R7 partial discarded", 1'b0);

    // pseudo-random streams compared every cycle (R4, R2, R6)
    cur_req = "R4";
    for (int run = 0; run < 6; run++) begin
      logic [7:0] lfsr;
      lfsr = 8'hA5 + 8'(run * 37);
      do_reset();
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr[2] | lfsr[6], lfsr[0]);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule